// File: doc/BRIEF.md
# Software Reset and Fail Control

This block sits next to a bus bridge and gives software a way to drive three active-low board signals: a local reset, a system reset and a system-fail line. Software reaches it over a small register bus with an address, a write strobe with write data, and a read strobe with registered read data. The block only drives these lines. Its own registers are cleared by the hardware reset input and by nothing else, so a local reset that software raises does not disturb the block that raised it.

There are three register views. The trigger register holds two write-one bits. Each bit launches a fixed-length pulse on one of the reset outputs, and both bits always read as zero. The set view and the clear view share one pair of state bits: a held board-reset request and the fail line. In the set view a one in a bit asserts that line, and in the clear view a one negates it. A read of either view returns the live asserted state of the local reset output and of the fail output. The local reset output is asserted while its trigger pulse runs or while the held board-reset bit is set.

Register offsets, the data width and the pulse length are parameters. Bit fields: in the trigger view bit 0 is the local trigger and bit 1 is the system trigger. In the set and clear views bit 0 is board reset and bit 1 is fail.

Top module: `swrst_ctl`

## Requirements
- R1: A write to the trigger offset with bit 0 set drives lrst_n_o low from the cycle after the write for exactly PULSE_LEN cycles (default 16). A write with bit 0 clear leaves lrst_n_o unchanged, and the local trigger never affects sysrst_n_o.
- R2: A write to the trigger offset with bit 1 set drives sysrst_n_o low from the cycle after the write for exactly PULSE_LEN cycles. A write with bit 1 clear leaves sysrst_n_o unchanged.
- R3: A read of the trigger offset always returns zero, including while a pulse is running.
- R4: A new trigger during a running pulse restarts the count, so the output stays low for PULSE_LEN cycles after the latest trigger write.
- R5: A write to the set offset with bit 0 set holds lrst_n_o low, and one with bit 1 set drives sysfail_n_o low from the next cycle. Zero bits have no effect, and sysfail_n_o changes only on a register write.
- R6: A write to the clear offset with bit 0 set releases the held board reset, and one with bit 1 set raises sysfail_n_o from the next cycle. Zero bits have no effect.
- R7: A read of the set or clear offset returns bit 0 = 1 when lrst_n_o is low, for either cause, and bit 1 = 1 when sysfail_n_o is low. All other bits read zero.
- R8: If the set and clear offsets decode the same write, the clear takes priority.
- R9: The hardware reset clears both state bits and stops any running pulse, so all outputs are high during and after reset. Software-driven reset outputs never clear the block's own state.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no output and no register state.
- R11: bus_rdata holds the read result in the cycle after bus_re is high and is zero in any cycle that follows a cycle with bus_re low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after bus_re |
| lrst_n_o | output | 1 | Local reset, active low |
| sysrst_n_o | output | 1 | System reset, active low |
| sysfail_n_o | output | 1 | System fail, active low |

## Verification
The assertions assume that bus_we and bus_re are never high in the same cycle. They also assume that bus_addr and bus_wdata are defined whenever a strobe is high, and that a read issued in the same cycle as a write would see the state from before that write. The stimulus strobes one access at a time, each for a single cycle, and holds the strobes low between accesses. It also drops the hardware reset only away from the clock edges. A second instance with the set and clear offsets made equal exercises the clear priority, using offsets that the first instance treats as unmapped.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    // Trigger view field positions
    localparam int unsigned TRG_LOCAL_BIT = 0;
    localparam int unsigned TRG_SYS_BIT   = 1;
    // Set / clear view field positions
    localparam int unsigned SC_BRST_BIT   = 0;
    localparam int unsigned SC_FAIL_BIT   = 1;
    // Number of pulse-stretched reset lines
    localparam int unsigned NUM_PULSE     = 2;
    localparam int unsigned PULSE_LOCAL   = 0;
    localparam int unsigned PULSE_SYS     = 1;

    typedef struct packed {
        logic brst;
        logic fail;
    } sc_state_t;
endpackage

// File: rtl/swrst_pulse.sv
module swrst_pulse #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pst_t;

    pst_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (trig) begin
            nxt_d.cnt = CNT_W'(LEN);
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign active = (cur_q.cnt != '0);
endmodule

// File: rtl/swrst_regs.sv
module swrst_regs
    import swrst_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFS_MISC = 'h00,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h04,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    input  logic              lrst_on,
    output logic [NUM_PULSE-1:0] trig,
    output sc_state_t         state,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        sc_state_t         sc;
        logic [DATA_W-1:0] rd;
    } rst_t;

    rst_t cur_q, nxt_d;
    logic hit_misc, hit_set, hit_clr;

    assign hit_misc = (bus_addr == OFS_MISC);
    assign hit_set  = (bus_addr == OFS_SET);
    assign hit_clr  = (bus_addr == OFS_CLR);

    always_comb begin
        trig = '0;
        if (bus_we && hit_misc) begin
            trig[PULSE_LOCAL] = bus_wdata[TRG_LOCAL_BIT];
            trig[PULSE_SYS]   = bus_wdata[TRG_SYS_BIT];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (bus_we && hit_set) begin
            if (bus_wdata[SC_BRST_BIT]) nxt_d.sc.brst = 1'b1;
            if (bus_wdata[SC_FAIL_BIT]) nxt_d.sc.fail = 1'b1;
        end
        // clear applied last so it wins on a shared decode
        if (bus_we && hit_clr) begin
            if (bus_wdata[SC_BRST_BIT]) nxt_d.sc.brst = 1'b0;
            if (bus_wdata[SC_FAIL_BIT]) nxt_d.sc.fail = 1'b0;
        end
        nxt_d.rd = '0;
        if (bus_re && (hit_set || hit_clr)) begin
            nxt_d.rd[SC_BRST_BIT] = lrst_on;
            nxt_d.rd[SC_FAIL_BIT] = cur_q.sc.fail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign state = cur_q.sc;
    assign rdata = cur_q.rd;
endmodule

// File: rtl/swrst_ctl.sv
module swrst_ctl
    import swrst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] OFS_MISC = 'h00,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h04,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h08,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              lrst_n_o,
    output logic              sysrst_n_o,
    output logic              sysfail_n_o
);
    logic [NUM_PULSE-1:0] trig;
    logic [NUM_PULSE-1:0] pact;
    sc_state_t            state;
    logic                 lrst_on;

    assign lrst_on = pact[PULSE_LOCAL] | state.brst;

    swrst_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_MISC(OFS_MISC), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .lrst_on(lrst_on),
        .trig(trig), .state(state), .rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
        swrst_pulse #(.LEN(PULSE_LEN)) u_pulse (
            .clk(clk), .rst_n(rst_n), .trig(trig[g]), .active(pact[g])
        );
    end

    assign lrst_n_o    = ~lrst_on;
    assign sysrst_n_o  = ~pact[PULSE_SYS];
    assign sysfail_n_o = ~state.fail;
endmodule

// File: rtl/swrst_chk.sv
module swrst_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFS_MISC = 'h00,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h04,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lrst_n_o,
    input logic              sysrst_n_o,
    input logic              sysfail_n_o
);
    logic at_misc, at_set, at_clr, unmapped;
    assign at_misc  = (bus_addr == OFS_MISC);
    assign at_set   = (bus_addr == OFS_SET);
    assign at_clr   = (bus_addr == OFS_CLR);
    assign unmapped = !(at_misc || at_set || at_clr);

    a_r1_local_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_misc && bus_wdata[0]) |=> !lrst_n_o);

    a_r2_sys_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_misc && bus_wdata[1]) |=> !sysrst_n_o);

    a_r3_misc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && at_misc) |=> (bus_rdata == '0));

    a_r5_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_set && !at_clr && bus_wdata[1]) |=> !sysfail_n_o);

    a_r5_fail_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(sysfail_n_o));

    // also covers R8: clear wins when both views decode
    a_r6_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_clr && bus_wdata[1]) |=> sysfail_n_o);

    a_r9_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lrst_n_o && sysrst_n_o && sysfail_n_o));

    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && unmapped) |=> (bus_rdata == '0));

    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));
endmodule

bind swrst_ctl swrst_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_MISC(OFS_MISC), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .lrst_n_o(lrst_n_o), .sysrst_n_o(sysrst_n_o), .sysfail_n_o(sysfail_n_o)
);

// File: tb/tb_swrst_ctl.sv
module tb_swrst_ctl;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int PL = 16;
    localparam logic [AW-1:0] A_MISC = 8'h00;
    localparam logic [AW-1:0] A_SET  = 8'h04;
    localparam logic [AW-1:0] A_CLR  = 8'h08;
    localparam logic [AW-1:0] A_SC2  = 8'h0C; // dut2 shared set/clear
    localparam logic [AW-1:0] A_NONE = 8'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_re = 1'b0;
    logic [DW-1:0] bus_rdata, rdata2;
    logic lrst_n_o, sysrst_n_o, sysfail_n_o;
    logic l2, s2, f2;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    swrst_ctl #(.ADDR_W(AW), .DATA_W(DW), .OFS_MISC(A_MISC), .OFS_SET(A_SET),
                .OFS_CLR(A_CLR), .PULSE_LEN(PL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .lrst_n_o(lrst_n_o), .sysrst_n_o(sysrst_n_o), .sysfail_n_o(sysfail_n_o));

    swrst_ctl #(.ADDR_W(AW), .DATA_W(DW), .OFS_MISC(A_MISC), .OFS_SET(A_SC2),
                .OFS_CLR(A_SC2), .PULSE_LEN(PL)) dut2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rdata2),
        .lrst_n_o(l2), .sysrst_n_o(s2), .sysfail_n_o(f2));

    // scoreboard for read results
    logic [DW-1:0] expq[$];
    string tagq[$];
    logic re_seen = 1'b0;

    always @(posedge clk) re_seen <= bus_re;

    always @(negedge clk) begin
        if (re_seen && expq.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic outs(input string tag, input logic l, input logic s, input logic f);
        chk(tag, {29'd0, lrst_n_o, sysrst_n_o, sysfail_n_o}, {29'd0, l, s, f});
    endtask

    // called at a negedge, returns at the following negedge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        bus_addr = a; bus_re = 1'b1;
        expq.push_back(e); tagq.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        outs("R9 outputs in reset", 1, 1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R9 outputs after reset", 1, 1, 1);
        rd(A_SET, 32'h0, "R9 state clear after reset");

        // R1/R2 zero writes do nothing
        wr(A_MISC, 32'h0);
        outs("R1 R2 zero trigger no effect", 1, 1, 1);
        rd(A_MISC, 32'h0, "R3 misc read idle");
        @(negedge clk);
        chk("R11 rdata zero after idle cycle", bus_rdata, 32'h0);

        // R1 local pulse length
        wr(A_MISC, 32'h1);
        outs("R1 local pulse start", 0, 1, 1);
        repeat (PL - 1) @(negedge clk);
        outs("R1 local pulse last cycle", 0, 1, 1);
        @(negedge clk);
        outs("R1 local pulse ended", 1, 1, 1);

        // R2 system pulse, R3 read during pulse
        wr(A_MISC, 32'h2);
        outs("R2 sys pulse start", 1, 0, 1);
        rd(A_MISC, 32'h0, "R3 misc read during pulse");
        repeat (PL - 2) @(negedge clk);
        outs("R2 sys pulse last cycle", 1, 0, 1);
        @(negedge clk);
        outs("R2 sys pulse ended", 1, 1, 1);

        // R4 retrigger
        wr(A_MISC, 32'h1);
        repeat (9) @(negedge clk);
        wr(A_MISC, 32'h1);
        repeat (PL - 1) @(negedge clk);
        outs("R4 retrigger extends pulse", 0, 1, 1);
        @(negedge clk);
        outs("R4 retriggered pulse ended", 1, 1, 1);

        // R7 read reflects trigger pulse
        wr(A_MISC, 32'h1);
        rd(A_CLR, 32'h1, "R7 clear view shows pulse");
        repeat (PL) @(negedge clk);

        // R5 set, R7 readback
        wr(A_SET, 32'h2);
        outs("R5 fail set", 1, 1, 0);
        rd(A_SET, 32'h2, "R7 set view fail");
        rd(A_CLR, 32'h2, "R7 clear view fail");
        wr(A_SET, 32'h1);
        outs("R5 board reset held", 0, 1, 0);
        rd(A_SET, 32'h3, "R7 both asserted");
        wr(A_SET, 32'h0);
        outs("R5 zero set no effect", 0, 1, 0);
        wr(A_CLR, 32'h0);
        outs("R6 zero clear no effect", 0, 1, 0);
        wr(A_CLR, 32'h2);
        outs("R6 fail cleared", 0, 1, 1);
        // R9 software pulse does not clear held state
        wr(A_MISC, 32'h1);
        repeat (PL + 2) @(negedge clk);
        outs("R9 held reset survives pulse", 0, 1, 1);
        rd(A_SET, 32'h1, "R9 state kept");
        wr(A_CLR, 32'h1);
        outs("R6 board reset released", 1, 1, 1);
        rd(A_CLR, 32'h0, "R6 both negated");

        // R10 unmapped
        wr(A_NONE, 32'hFFFF_FFFF);
        outs("R10 unmapped write ignored", 1, 1, 1);
        rd(A_SET, 32'h0, "R10 state unchanged");
        rd(A_NONE, 32'h0, "R10 unmapped read zero");

        // R8 shared decode in dut2 (A_SC2 unmapped for dut)
        wr(A_SC2, 32'h3);
        chk("R8 clear wins", {29'd0, l2, s2, f2}, 32'h7);
        outs("R10 dut ignores other offset", 1, 1, 1);
        rd(A_SC2, 32'h0, "R10 unmapped read dut");
        chk("R8 dut2 reads negated", rdata2, 32'h0);

        // R9 hardware reset stops pulse and state
        wr(A_SET, 32'h3);
        wr(A_MISC, 32'h2);
        outs("R9 before reset", 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        outs("R9 reset mid pulse", 1, 1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R9 after mid-pulse reset", 1, 1, 1);
        rd(A_SET, 32'h0, "R9 state cleared");
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule